// File: doc/BRIEF.md
# Replay-Sphere Chunk Commit Arbiter

This block is the central decision point for chunk commits in a multiprocessor that records and replays the interleaving of threads in groups called replay spheres. Each processor raises a commit request. The arbiter finds which thread runs on that processor and which sphere owns the thread, then grants or withholds the commit according to that sphere's mode. A sphere in Standard mode commits freely. A Recording sphere appends the committing thread's ID to its own interleaving log. A Replaying sphere lets a commit through only when the thread at the head of its log is the one asking.

Software sets up the block through three host write ports. One port fills the per-processor thread table. One fills the per-sphere control table, which holds the mode and the base, current and limit pointers. One preloads log words for replay. Every sphere owns a window of one shared log memory. Each sphere has a sticky overflow flag and a sticky underflow flag, and the block drives both out. Requests and grants are one bit per processor. There is one decision per cycle, and processors take turns in round-robin order.

Top module: `sca_commit_arb`

## Requirements
- R1: After reset the thread table and the sphere table are empty, all overflow and underflow flags are 0, and the round-robin pointer selects processor 0 first.
- R2: When the requester's thread entry is invalid, or its sphere entry is invalid, the commit is granted in the same cycle and no log pointer moves.
- R3: A sphere whose mode code is Standard (code 0, and the unused code 3) grants the commit without touching its log.
- R4: A Recording sphere (code 1) whose current pointer is below its limit grants the commit, stores the thread ID at the current pointer and advances the pointer by one.
- R5: A Recording sphere whose current pointer has reached its limit withholds the grant and sets that sphere's overflow flag. The flag stays set until the sphere entry is rewritten.
- R6: A Replaying sphere (code 2) grants the commit when the log word at the current pointer equals the requester's thread ID, and it then advances the pointer.
- R7: In a Replaying sphere a request whose thread ID differs from the log head is withheld and the log head is kept.
- R8: A Replaying sphere whose current pointer has reached its limit withholds the grant and sets that sphere's underflow flag. The flag is sticky in the same way as the overflow flag.
- R9: At most one grant is high in any cycle, and a grant goes only to a processor that is requesting.
- R10: Each cycle the block serves the first requesting processor at or after the round-robin pointer. After every served request, granted or not, the pointer moves to the next processor.
- R11: Writing a sphere entry sets its current pointer to the written base and clears both of its flags.
- R12: Spheres are independent. Recording or replaying in one sphere changes neither the log window, the pointer nor the flags of another sphere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NPROC | Commit request, one bit per processor |
| gnt_o | output | NPROC | Commit grant, valid in the same cycle as the request |
| thr_we_i | input | 1 | Thread table write strobe |
| thr_sel_i | input | PSEL_W | Processor whose thread entry is written |
| thr_valid_i | input | 1 | Thread entry valid (0 = null) |
| thr_tid_i | input | TID_W | Thread ID |
| thr_sph_i | input | SSEL_W | Sphere index of the thread |
| sph_we_i | input | 1 | Sphere table write strobe |
| sph_sel_i | input | SSEL_W | Sphere entry written |
| sph_valid_i | input | 1 | Sphere entry valid (0 = null) |
| sph_mode_i | input | 2 | Mode: 0 Standard, 1 Recording, 2 Replaying |
| sph_base_i | input | PTR_W | Log window base; also loaded into the current pointer |
| sph_limit_i | input | PTR_W | Log window limit (exclusive) |
| log_we_i | input | 1 | Log preload write strobe |
| log_addr_i | input | LA_W | Log preload address |
| log_tag_i | input | TID_W | Log preload thread ID |
| ovf_o | output | NSPH | Sticky overflow flag per sphere |
| unf_o | output | NSPH | Sticky underflow flag per sphere |

## Verification
A wrong log pointer or a wrongly stored tag does not show at once during recording. It shows when the same window is replayed: in the first cycle of the replay, the thread that committed first is withheld, or the wrong thread is granted. The bench therefore records a commit order, replays it and checks every grant, mismatches included. A bad round-robin pointer shows as the wrong grant bit in the next cycle with several requesters. The bench sweeps every request mask against an arithmetic model of the pointer. A flag that fails to set or to stay set is visible on the flag outputs one cycle after the commit that should have raised it.

// File: rtl/sca_pkg.sv
package sca_pkg;

  typedef enum logic [1:0] {
    MD_STD = 2'd0,
    MD_REC = 2'd1,
    MD_RPL = 2'd2,
    MD_RSV = 2'd3
  } mode_e;

  // Effective mode seen by a commit: null entries behave as Standard.
  function automatic mode_e eff_mode(logic thr_ok, logic sph_ok, logic [1:0] code);
    if (!thr_ok || !sph_ok) return MD_STD;
    case (code)
      2'd1:    return MD_REC;
      2'd2:    return MD_RPL;
      default: return MD_STD;
    endcase
  endfunction

endpackage

// File: rtl/sca_rr_pick.sv
module sca_rr_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic         pick_vld,
  output logic [W-1:0] pick_idx
);

  logic [W-1:0] ptr_q;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(int'(ptr_q) + k) % N]) begin
        pick_vld = 1'b1;
        pick_idx = W'((int'(ptr_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (pick_vld) begin
      ptr_q <= (pick_idx == W'(N - 1)) ? '0 : pick_idx + W'(1);
    end
  end

endmodule

// File: rtl/sca_thread_tbl.sv
module sca_thread_tbl #(
  parameter int NPROC  = 4,
  parameter int TID_W  = 4,
  parameter int SSEL_W = 2,
  localparam int PSEL_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PSEL_W-1:0] wsel,
  input  logic              wvalid,
  input  logic [TID_W-1:0]  wtid,
  input  logic [SSEL_W-1:0] wsph,
  input  logic [PSEL_W-1:0] rsel,
  output logic              rvalid,
  output logic [TID_W-1:0]  rtid,
  output logic [SSEL_W-1:0] rsph
);

  logic [NPROC-1:0]  valid_q;
  logic [TID_W-1:0]  tid_q [NPROC];
  logic [SSEL_W-1:0] sph_q [NPROC];

  for (genvar p = 0; p < NPROC; p++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[p] <= 1'b0;
        tid_q[p]   <= '0;
        sph_q[p]   <= '0;
      end else if (we && wsel == PSEL_W'(p)) begin
        valid_q[p] <= wvalid;
        tid_q[p]   <= wtid;
        sph_q[p]   <= wsph;
      end
    end
  end

  assign rvalid = valid_q[rsel];
  assign rtid   = tid_q[rsel];
  assign rsph   = sph_q[rsel];

endmodule

// File: rtl/sca_sphere_tbl.sv
module sca_sphere_tbl #(
  parameter int NSPH  = 4,
  parameter int PTR_W = 5,
  localparam int SSEL_W = (NSPH > 1) ? $clog2(NSPH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SSEL_W-1:0] wsel,
  input  logic              wvalid,
  input  logic [1:0]        wmode,
  input  logic [PTR_W-1:0]  wbase,
  input  logic [PTR_W-1:0]  wlimit,
  input  logic [SSEL_W-1:0] rsel,
  output logic              rvalid,
  output logic [1:0]        rmode,
  output logic [PTR_W-1:0]  rcur,
  output logic [PTR_W-1:0]  rlimit,
  input  logic              adv,
  input  logic              set_ovf,
  input  logic              set_unf,
  output logic [NSPH-1:0]   ovf,
  output logic [NSPH-1:0]   unf
);

  logic [NSPH-1:0]  valid_q;
  logic [1:0]       mode_q  [NSPH];
  logic [PTR_W-1:0] cur_q   [NSPH];
  logic [PTR_W-1:0] limit_q [NSPH];
  logic [NSPH-1:0]  ovf_q, unf_q;

  for (genvar s = 0; s < NSPH; s++) begin : g_ent
    logic host_hit, eng_hit;
    assign host_hit = we && wsel == SSEL_W'(s);
    assign eng_hit  = rsel == SSEL_W'(s);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
        mode_q[s]  <= 2'd0;
        cur_q[s]   <= '0;
        limit_q[s] <= '0;
        ovf_q[s]   <= 1'b0;
        unf_q[s]   <= 1'b0;
      end else if (host_hit) begin
        valid_q[s] <= wvalid;
        mode_q[s]  <= wmode;
        cur_q[s]   <= wbase;
        limit_q[s] <= wlimit;
        ovf_q[s]   <= 1'b0;
        unf_q[s]   <= 1'b0;
      end else if (eng_hit) begin
        if (adv)     cur_q[s] <= cur_q[s] + PTR_W'(1);
        if (set_ovf) ovf_q[s] <= 1'b1;
        if (set_unf) unf_q[s] <= 1'b1;
      end
    end
  end

  assign rvalid = valid_q[rsel];
  assign rmode  = mode_q[rsel];
  assign rcur   = cur_q[rsel];
  assign rlimit = limit_q[rsel];
  assign ovf    = ovf_q;
  assign unf    = unf_q;

endmodule

// File: rtl/sca_log_mem.sv
module sca_log_mem #(
  parameter int DEPTH = 16,
  parameter int TID_W = 4,
  localparam int LA_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [LA_W-1:0]  host_addr,
  input  logic [TID_W-1:0] host_tag,
  input  logic             eng_we,
  input  logic [LA_W-1:0]  eng_addr,
  input  logic [TID_W-1:0] eng_tag,
  input  logic [LA_W-1:0]  rd_addr,
  output logic [TID_W-1:0] rd_tag
);

  logic [TID_W-1:0] mem_q [DEPTH];

  // The engine's record write takes precedence over a host preload.
  always_ff @(posedge clk) begin
    if (eng_we)       mem_q[eng_addr]  <= eng_tag;
    else if (host_we) mem_q[host_addr] <= host_tag;
  end

  assign rd_tag = mem_q[rd_addr];

endmodule

// File: rtl/sca_commit_arb.sv
module sca_commit_arb #(
  parameter int NPROC     = 4,
  parameter int NSPH      = 4,
  parameter int TID_W     = 4,
  parameter int LOG_DEPTH = 16,
  localparam int PSEL_W = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int SSEL_W = (NSPH > 1) ? $clog2(NSPH) : 1,
  localparam int LA_W   = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
  localparam int PTR_W  = LA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPROC-1:0]  req_i,
  output logic [NPROC-1:0]  gnt_o,
  input  logic              thr_we_i,
  input  logic [PSEL_W-1:0] thr_sel_i,
  input  logic              thr_valid_i,
  input  logic [TID_W-1:0]  thr_tid_i,
  input  logic [SSEL_W-1:0] thr_sph_i,
  input  logic              sph_we_i,
  input  logic [SSEL_W-1:0] sph_sel_i,
  input  logic              sph_valid_i,
  input  logic [1:0]        sph_mode_i,
  input  logic [PTR_W-1:0]  sph_base_i,
  input  logic [PTR_W-1:0]  sph_limit_i,
  input  logic              log_we_i,
  input  logic [LA_W-1:0]   log_addr_i,
  input  logic [TID_W-1:0]  log_tag_i,
  output logic [NSPH-1:0]   ovf_o,
  output logic [NSPH-1:0]   unf_o
);
  import sca_pkg::*;

  function automatic logic window_done(logic [PTR_W-1:0] cur, logic [PTR_W-1:0] lim);
    return cur >= lim;
  endfunction

  function automatic logic [NPROC-1:0] dec_onehot(logic [PSEL_W-1:0] idx);
    logic [NPROC-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  logic              pick_vld;
  logic [PSEL_W-1:0] pick_idx;
  logic              t_valid;
  logic [TID_W-1:0]  t_tid;
  logic [SSEL_W-1:0] t_sph;
  logic              s_valid;
  logic [1:0]        s_mode;
  logic [PTR_W-1:0]  s_cur, s_limit;
  logic [TID_W-1:0]  head_tag;
  mode_e             cur_mode;
  logic              at_end;

  // Named events, observed by the bound checker.
  logic ev_std, ev_rec, ev_ovf, ev_pop, ev_unf, ev_grant;

  sca_rr_pick #(.N(NPROC)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_i),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  sca_thread_tbl #(.NPROC(NPROC), .TID_W(TID_W), .SSEL_W(SSEL_W)) u_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (thr_we_i),
    .wsel   (thr_sel_i),
    .wvalid (thr_valid_i),
    .wtid   (thr_tid_i),
    .wsph   (thr_sph_i),
    .rsel   (pick_idx),
    .rvalid (t_valid),
    .rtid   (t_tid),
    .rsph   (t_sph)
  );

  sca_sphere_tbl #(.NSPH(NSPH), .PTR_W(PTR_W)) u_sph (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (sph_we_i),
    .wsel    (sph_sel_i),
    .wvalid  (sph_valid_i),
    .wmode   (sph_mode_i),
    .wbase   (sph_base_i),
    .wlimit  (sph_limit_i),
    .rsel    (t_sph),
    .rvalid  (s_valid),
    .rmode   (s_mode),
    .rcur    (s_cur),
    .rlimit  (s_limit),
    .adv     (ev_rec | ev_pop),
    .set_ovf (ev_ovf),
    .set_unf (ev_unf),
    .ovf     (ovf_o),
    .unf     (unf_o)
  );

  sca_log_mem #(.DEPTH(LOG_DEPTH), .TID_W(TID_W)) u_log (
    .clk       (clk),
    .host_we   (log_we_i),
    .host_addr (log_addr_i),
    .host_tag  (log_tag_i),
    .eng_we    (ev_rec),
    .eng_addr  (s_cur[LA_W-1:0]),
    .eng_tag   (t_tid),
    .rd_addr   (s_cur[LA_W-1:0]),
    .rd_tag    (head_tag)
  );

  assign cur_mode = eff_mode(t_valid, s_valid, s_mode);
  assign at_end   = window_done(s_cur, s_limit);

  assign ev_std   = pick_vld && cur_mode == MD_STD;
  assign ev_rec   = pick_vld && cur_mode == MD_REC && !at_end;
  assign ev_ovf   = pick_vld && cur_mode == MD_REC && at_end;
  assign ev_pop   = pick_vld && cur_mode == MD_RPL && !at_end && head_tag == t_tid;
  assign ev_unf   = pick_vld && cur_mode == MD_RPL && at_end;
  assign ev_grant = ev_std | ev_rec | ev_pop;

  assign gnt_o = ev_grant ? dec_onehot(pick_idx) : '0;

endmodule

// File: rtl/sca_commit_arb_chk.sv
module sca_commit_arb_chk #(
  parameter int NPROC = 4,
  parameter int NSPH  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROC-1:0] req_i,
  input logic [NPROC-1:0] gnt_o,
  input logic             sph_we_i,
  input logic [NSPH-1:0]  ovf_o,
  input logic [NSPH-1:0]  unf_o,
  input logic             ev_ovf,
  input logic             ev_unf,
  input logic             ev_pop,
  input logic             ev_rec
);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  p_only_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);

  p_ovf_nogrant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |-> gnt_o == '0);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sph_we_i |=> (ovf_o & $past(ovf_o)) == $past(ovf_o));

  p_ovf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o & ~$past(ovf_o)) != '0 |-> $past(ev_ovf));

  p_unf_nogrant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |-> gnt_o == '0);

  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sph_we_i |=> (unf_o & $past(unf_o)) == $past(unf_o));

  p_unf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_o & ~$past(unf_o)) != '0 |-> $past(ev_unf));

  p_pop_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |-> $onehot(gnt_o));

  p_rec_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rec |-> $onehot(gnt_o));

endmodule

bind sca_commit_arb sca_commit_arb_chk #(.NPROC(NPROC), .NSPH(NSPH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .gnt_o    (gnt_o),
  .sph_we_i (sph_we_i),
  .ovf_o    (ovf_o),
  .unf_o    (unf_o),
  .ev_ovf   (ev_ovf),
  .ev_unf   (ev_unf),
  .ev_pop   (ev_pop),
  .ev_rec   (ev_rec)
);

// File: tb/sca_commit_arb_bench.sv
module sca_commit_arb_bench;

  localparam int NP = 4;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req_i = '0;
  logic [NP-1:0] gnt_o;
  logic          thr_we_i = 0, thr_valid_i = 0;
  logic [1:0]    thr_sel_i = '0, thr_sph_i = '0;
  logic [3:0]    thr_tid_i = '0;
  logic          sph_we_i = 0, sph_valid_i = 0;
  logic [1:0]    sph_sel_i = '0, sph_mode_i = '0;
  logic [4:0]    sph_base_i = '0, sph_limit_i = '0;
  logic          log_we_i = 0;
  logic [3:0]    log_addr_i = '0, log_tag_i = '0;
  logic [NS-1:0] ovf_o, unf_o;

  int n_tests = 0;
  int n_fail  = 0;
  int rr_ptr  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  sca_commit_arb #(.NPROC(NP), .NSPH(NS), .TID_W(4), .LOG_DEPTH(16)) u_sca_commit_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_o(gnt_o),
    .thr_we_i(thr_we_i), .thr_sel_i(thr_sel_i), .thr_valid_i(thr_valid_i),
    .thr_tid_i(thr_tid_i), .thr_sph_i(thr_sph_i),
    .sph_we_i(sph_we_i), .sph_sel_i(sph_sel_i), .sph_valid_i(sph_valid_i),
    .sph_mode_i(sph_mode_i), .sph_base_i(sph_base_i), .sph_limit_i(sph_limit_i),
    .log_we_i(log_we_i), .log_addr_i(log_addr_i), .log_tag_i(log_tag_i),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_thr(input int p, input bit v, input int tid, input int s);
    @(negedge clk);
    thr_we_i = 1; thr_sel_i = 2'(p); thr_valid_i = v; thr_tid_i = 4'(tid); thr_sph_i = 2'(s);
    @(negedge clk);
    thr_we_i = 0;
  endtask

  task automatic set_sph(input int s, input bit v, input int md, input int base, input int lim);
    @(negedge clk);
    sph_we_i = 1; sph_sel_i = 2'(s); sph_valid_i = v; sph_mode_i = 2'(md);
    sph_base_i = 5'(base); sph_limit_i = 5'(lim);
    @(negedge clk);
    sph_we_i = 0;
  endtask

  task automatic set_log(input int a, input int tag);
    @(negedge clk);
    log_we_i = 1; log_addr_i = 4'(a); log_tag_i = 4'(tag);
    @(negedge clk);
    log_we_i = 0;
  endtask

  // Presents a request mask for one cycle; returns the grant seen before the edge.
  task automatic commit(input logic [NP-1:0] mask, output logic [NP-1:0] g);
    @(negedge clk);
    req_i = mask;
    #1 g = gnt_o;
    @(posedge clk);
    #1 req_i = '0;
    if (mask != '0) begin
      for (int k = 0; k < NP; k++) begin
        if (mask[(rr_ptr + k) % NP]) begin
          rr_ptr = ((rr_ptr + k) % NP + 1) % NP;
          break;
        end
      end
    end
  endtask

  function automatic logic [NP-1:0] rr_expect(input logic [NP-1:0] mask, input int ptr);
    for (int k = 0; k < NP; k++)
      if (mask[(ptr + k) % NP]) return NP'(1) << ((ptr + k) % NP);
    return '0;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] g;
    logic [NP-1:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: flags clear, first service goes to processor 0, tables empty
    check(ovf_o == '0 && unf_o == '0, "R1 flags", {ovf_o, unf_o}, 0);
    commit(4'b1111, g);
    check(g == 4'b0001, "R1 first grant", g, 4'b0001);

    // R10 / R2: sweep all masks twice with null tables, model the pointer
    for (int rep = 0; rep < 2; rep++) begin
      for (int m = 1; m < 16; m++) begin
        e = rr_expect(4'(m), rr_ptr);
        commit(4'(m), g);
        check(g == e, "R10 round robin", g, e);
      end
    end
    for (int k = 0; k < 5; k++) begin
      e = rr_expect(4'b1111, rr_ptr);
      commit(4'b1111, g);
      check(g == e, "R9 single grant rotation", g, e);
    end

    // R3: Standard sphere (code 0) and reserved code 3
    set_sph(1, 1, 0, 0, 0);
    set_thr(1, 1, 6, 1);
    commit(4'b0010, g);
    check(g == 4'b0010, "R3 standard", g, 4'b0010);
    set_sph(1, 1, 3, 0, 0);
    commit(4'b0010, g);
    check(g == 4'b0010, "R3 code3", g, 4'b0010);

    // R4: recording in sphere 0, window [0,4)
    set_sph(0, 1, 1, 0, 4);
    set_thr(0, 1, 3, 0);
    set_thr(1, 1, 5, 0);
    set_thr(2, 1, 9, 0);
    commit(4'b0010, g); check(g == 4'b0010, "R4 rec p1", g, 4'b0010);
    commit(4'b0001, g); check(g == 4'b0001, "R4 rec p0", g, 4'b0001);
    commit(4'b0100, g); check(g == 4'b0100, "R4 rec p2", g, 4'b0100);
    commit(4'b0001, g); check(g == 4'b0001, "R4 rec p0 again", g, 4'b0001);

    // R5: window full
    commit(4'b0010, g); check(g == 4'b0000, "R5 full withheld", g, 0);
    @(negedge clk);
    check(ovf_o == 4'b0001, "R5 ovf set", ovf_o, 4'b0001);
    commit(4'b0010, g); check(g == 4'b0000, "R5 still withheld", g, 0);
    @(negedge clk);
    check(ovf_o == 4'b0001, "R5 ovf sticky", ovf_o, 4'b0001);

    // R11: rewrite sphere 0 to replay the recorded window
    set_sph(0, 1, 2, 0, 4);
    check(ovf_o == '0 && unf_o == '0, "R11 flags cleared", {ovf_o, unf_o}, 0);

    // R7: wrong thread first is withheld, head kept
    commit(4'b0001, g); check(g == 4'b0000, "R7 mismatch", g, 0);
    commit(4'b0100, g); check(g == 4'b0000, "R7 mismatch p2", g, 0);
    // R6: recorded order 5,3,9,3 replays
    commit(4'b0010, g); check(g == 4'b0010, "R6 replay p1", g, 4'b0010);
    commit(4'b0100, g); check(g == 4'b0000, "R7 out of order p2", g, 0);
    commit(4'b0001, g); check(g == 4'b0001, "R6 replay p0", g, 4'b0001);
    commit(4'b0100, g); check(g == 4'b0100, "R6 replay p2", g, 4'b0100);
    commit(4'b0001, g); check(g == 4'b0001, "R6 replay p0 last", g, 4'b0001);
    // R8: exhausted
    commit(4'b0001, g); check(g == 4'b0000, "R8 empty withheld", g, 0);
    @(negedge clk);
    check(unf_o == 4'b0001, "R8 unf set", unf_o, 4'b0001);
    check(ovf_o == 4'b0000, "R8 no ovf", ovf_o, 0);

    // R12: sphere 2 replays preloaded [8,10), sphere 3 records [10,12)
    set_log(8, 7);
    set_log(9, 7);
    set_sph(2, 1, 2, 8, 10);
    set_sph(3, 1, 1, 10, 12);
    set_thr(3, 1, 7, 2);
    set_thr(2, 1, 9, 3);
    commit(4'b0100, g); check(g == 4'b0100, "R12 rec s3", g, 4'b0100);
    commit(4'b1000, g); check(g == 4'b1000, "R12 replay s2 first", g, 4'b1000);
    commit(4'b0100, g); check(g == 4'b0100, "R12 rec s3 second", g, 4'b0100);
    commit(4'b1000, g); check(g == 4'b1000, "R12 replay s2 second", g, 4'b1000);
    commit(4'b0100, g); check(g == 4'b0000, "R12 s3 full", g, 0);
    commit(4'b1000, g); check(g == 4'b0000, "R12 s2 empty", g, 0);
    @(negedge clk);
    check(ovf_o == 4'b1000, "R12 ovf only s3", ovf_o, 4'b1000);
    check(unf_o == 4'b0101, "R12 unf s0 s2", unf_o, 4'b0101);

    // R2: null sphere and null thread entries grant, no pointer move
    set_sph(0, 0, 2, 0, 0);
    commit(4'b0001, g); check(g == 4'b0001, "R2 null sphere", g, 4'b0001);
    set_thr(3, 0, 7, 2);
    commit(4'b1000, g); check(g == 4'b1000, "R2 null thread", g, 4'b1000);
    set_thr(3, 1, 7, 2);
    commit(4'b1000, g); check(g == 4'b0000, "R2 s2 unchanged empty", g, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule